// File: doc/BRIEF.md
# Operand Effective Address Generator

This block resolves the operand of an 8-bit style instruction. It is given a mode code, the address of the instruction (the program counter) and the value of the X index register. It then fetches the bytes it needs through a byte-wide synchronous read port and returns one of three results: an immediate operand byte, a 16-bit effective address, or nothing. In every case it signals completion with a one-cycle done pulse. A mode code it does not support produces a one-cycle error pulse instead.

The read port has one cycle of latency, and the generator issues at most one read per cycle. Multi-byte values are assembled little-endian. The indexed-indirect mode keeps both its pointer arithmetic and its pointer increment inside the zero page. Relative mode sign-extends its offset byte and adds it to the program counter with 16-bit wraparound. A sequencer fetches the bytes, and the result register presents the outcome on registered outputs.

Top module: `opnd_addr_unit`

## Requirements
- R1: While reset is high, and in the cycle after it, busy, done, err, rd_en, opnd_vld and ea_vld are all 0.
- R2: Mode codes 0 (implied) and 1 (accumulator) issue no read. They give done on the 1st rising edge after the edge that samples start, with opnd_vld and ea_vld both 0.
- R3: Mode code 2 (immediate) reads PC+1 once. It gives done on the 2nd edge with opnd_vld=1 and opnd equal to that byte.
- R4: Mode code 3 (absolute) reads PC+1 and then PC+2 (PC+1 and PC+2 wrap at 16 bits). It gives done on the 3rd edge with ea_vld=1 and ea = {byte at PC+2, byte at PC+1}.
- R5: Mode code 4 (zero page) reads PC+1 once. It gives done on the 2nd edge with ea_vld=1 and ea = {8'h00, byte}.
- R6: Mode code 5 (X-indexed indirect) reads PC+1, then {8'h00, P}, then {8'h00, P+1}, where P = (byte + X) mod 256 and P+1 also wraps mod 256. It gives done on the 5th edge with ea = {third byte, second byte}.
- R7: Mode code 6 (relative) reads PC+1 once. It gives done on the 2nd edge with ea = (PC + sign-extended byte) mod 65536.
- R8: Mode codes 7 to 15 issue no read. They give err on the 1st edge, and done does not pulse.
- R9: busy rises on the edge that accepts start and falls on the edge that raises done or err. A start seen while busy is ignored and does not alter the result.
- R10: rd_en is high only while busy, and each read the sequence issues appears as exactly one cycle of rd_en.
- R11: done and err are single-cycle pulses that are never high together. opnd_vld and ea_vld are only high together with done.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving; sampled only while idle |
| mode | input | 4 | Addressing-mode code |
| pc | input | 16 | Address of the instruction |
| xreg | input | 8 | X index register value |
| rd_en | output | 1 | Read request to memory |
| rd_addr | output | 16 | Read address |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle unsupported-mode pulse |
| opnd_vld | output | 1 | opnd holds an immediate byte (with done) |
| opnd | output | 8 | Immediate operand |
| ea_vld | output | 1 | ea holds an effective address (with done) |
| ea | output | 16 | Effective address |

## Verification
The bound checker tests the following on every cycle:
- done and err are exclusive single pulses.
- The valid flags appear only alongside done.
- Reads are issued only while busy.
- busy rises only after a start and falls only with a completion pulse.

Only the bench scenarios can show whether the numbers are right. These cover:
- the exact latency of each mode;
- the address sequence presented to memory;
- little-endian assembly;
- zero-page wraparound of both the indexed pointer and its increment;
- sign extension across the 16-bit boundary;
- the fact that a start pulse arriving mid-operation leaves the result untouched.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] M_IMPL = MODE_W'(0);
  localparam logic [MODE_W-1:0] M_ACC  = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_IMM  = MODE_W'(2);
  localparam logic [MODE_W-1:0] M_ABS  = MODE_W'(3);
  localparam logic [MODE_W-1:0] M_ZPG  = MODE_W'(4);
  localparam logic [MODE_W-1:0] M_XIND = MODE_W'(5);
  localparam logic [MODE_W-1:0] M_REL  = MODE_W'(6);

  typedef enum logic [2:0] {
    S_IDLE, S_NOREAD, S_B1_WAIT, S_B1_GOT,
    S_HI_GOT, S_PTR_NEXT, S_PLO_GOT, S_PHI_GOT
  } seq_e;

  typedef enum logic [1:0] {K_NONE, K_OPND, K_ADDR} kind_e;

  function automatic logic mode_reads(input logic [MODE_W-1:0] m);
    return (m >= M_IMM) && (m <= M_REL);
  endfunction

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    return m <= M_REL;
  endfunction
endpackage

// File: rtl/eag_arith.sv
module eag_arith #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] pc_q,
  input  logic [DW-1:0] x_q,
  input  logic [DW-1:0] byte_in,
  input  logic [DW-1:0] ptr_q,
  output logic [AW-1:0] rel_tgt,
  output logic [AW-1:0] zp_ea,
  output logic [DW-1:0] ptr_sum,
  output logic [DW-1:0] ptr_inc
);
  localparam int ZW = AW - DW;

  // relative target: sign extension then modular add
  assign rel_tgt = pc_q + {{ZW{byte_in[DW-1]}}, byte_in};
  assign zp_ea   = {{ZW{1'b0}}, byte_in};
  // both pointer operations stay inside the zero page by width
  assign ptr_sum = byte_in + x_q;
  assign ptr_inc = ptr_q + DW'(1);
endmodule

// File: rtl/eag_seq.sv
module eag_seq
  import eag_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     pc,
  input  logic [DW-1:0]     xreg,
  input  logic [DW-1:0]     rd_data,
  input  logic [AW-1:0]     rel_tgt,
  input  logic [AW-1:0]     zp_ea,
  input  logic [DW-1:0]     ptr_sum,
  input  logic [DW-1:0]     ptr_inc,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic [AW-1:0]     pc_q,
  output logic [DW-1:0]     x_q,
  output logic [DW-1:0]     ptr_q,
  output logic              accept,
  output logic              fin_ok,
  output logic              fin_err,
  output kind_e             fin_kind,
  output logic [AW-1:0]     fin_ea,
  output logic [DW-1:0]     fin_opnd
);
  localparam int ZW = AW - DW;

  seq_e              st;
  logic [MODE_W-1:0] mode_q;
  logic [DW-1:0]     lo_q;

  assign accept = (st == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      mode_q  <= '0;
      pc_q    <= '0;
      x_q     <= '0;
      ptr_q   <= '0;
      lo_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mode_q <= mode;
          pc_q   <= pc;
          x_q    <= xreg;
          if (mode_reads(mode)) begin
            rd_en   <= 1'b1;
            rd_addr <= pc + AW'(1);
            st      <= S_B1_WAIT;
          end else begin
            st <= S_NOREAD;
          end
        end
        S_NOREAD: st <= S_IDLE;
        S_B1_WAIT: begin
          if (mode_q == M_ABS) rd_addr <= pc_q + AW'(2);
          else                 rd_en   <= 1'b0;
          st <= S_B1_GOT;
        end
        S_B1_GOT: begin
          if (mode_q == M_ABS) begin
            lo_q  <= rd_data;
            rd_en <= 1'b0;
            st    <= S_HI_GOT;
          end else if (mode_q == M_XIND) begin
            ptr_q   <= ptr_sum;
            rd_en   <= 1'b1;
            rd_addr <= {{ZW{1'b0}}, ptr_sum};
            st      <= S_PTR_NEXT;
          end else begin
            st <= S_IDLE;
          end
        end
        S_HI_GOT: st <= S_IDLE;
        S_PTR_NEXT: begin
          rd_addr <= {{ZW{1'b0}}, ptr_inc};
          st      <= S_PLO_GOT;
        end
        S_PLO_GOT: begin
          lo_q  <= rd_data;
          rd_en <= 1'b0;
          st    <= S_PHI_GOT;
        end
        S_PHI_GOT: st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    fin_ok   = 1'b0;
    fin_err  = 1'b0;
    fin_kind = K_NONE;
    fin_ea   = '0;
    fin_opnd = rd_data;
    case (st)
      S_NOREAD: begin
        fin_ok  = mode_known(mode_q);
        fin_err = !mode_known(mode_q);
      end
      S_B1_GOT: begin
        if (mode_q == M_IMM) begin
          fin_ok   = 1'b1;
          fin_kind = K_OPND;
        end else if (mode_q == M_ZPG) begin
          fin_ok   = 1'b1;
          fin_kind = K_ADDR;
          fin_ea   = zp_ea;
        end else if (mode_q == M_REL) begin
          fin_ok   = 1'b1;
          fin_kind = K_ADDR;
          fin_ea   = rel_tgt;
        end
      end
      S_HI_GOT, S_PHI_GOT: begin
        fin_ok   = 1'b1;
        fin_kind = K_ADDR;
        fin_ea   = {rd_data, lo_q};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eag_result.sv
module eag_result
  import eag_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          fin_ok,
  input  logic          fin_err,
  input  kind_e         fin_kind,
  input  logic [AW-1:0] fin_ea,
  input  logic [DW-1:0] fin_opnd,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          opnd_vld,
  output logic [DW-1:0] opnd,
  output logic          ea_vld,
  output logic [AW-1:0] ea
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      opnd_vld <= 1'b0;
      opnd     <= '0;
      ea_vld   <= 1'b0;
      ea       <= '0;
    end else begin
      done     <= fin_ok;
      err      <= fin_err;
      opnd_vld <= fin_ok && (fin_kind == K_OPND);
      ea_vld   <= fin_ok && (fin_kind == K_ADDR);
      if (fin_ok && fin_kind == K_OPND) opnd <= fin_opnd;
      if (fin_ok && fin_kind == K_ADDR) ea   <= fin_ea;
      if (accept)                busy <= 1'b1;
      else if (fin_ok || fin_err) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import eag_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     pc,
  input  logic [DW-1:0]     xreg,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [DW-1:0]     rd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              opnd_vld,
  output logic [DW-1:0]     opnd,
  output logic              ea_vld,
  output logic [AW-1:0]     ea
);
  logic [AW-1:0] pc_q, rel_tgt, zp_ea, fin_ea;
  logic [DW-1:0] x_q, ptr_q, ptr_sum, ptr_inc, fin_opnd;
  logic          accept, fin_ok, fin_err;
  kind_e         fin_kind;

  eag_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .pc(pc), .xreg(xreg),
    .rd_data(rd_data), .rel_tgt(rel_tgt), .zp_ea(zp_ea), .ptr_sum(ptr_sum),
    .ptr_inc(ptr_inc), .rd_en(rd_en), .rd_addr(rd_addr), .pc_q(pc_q),
    .x_q(x_q), .ptr_q(ptr_q), .accept(accept), .fin_ok(fin_ok),
    .fin_err(fin_err), .fin_kind(fin_kind), .fin_ea(fin_ea),
    .fin_opnd(fin_opnd)
  );

  eag_arith #(.AW(AW), .DW(DW)) u_arith (
    .pc_q(pc_q), .x_q(x_q), .byte_in(rd_data), .ptr_q(ptr_q),
    .rel_tgt(rel_tgt), .zp_ea(zp_ea), .ptr_sum(ptr_sum), .ptr_inc(ptr_inc)
  );

  eag_result #(.AW(AW), .DW(DW)) u_res (
    .clk(clk), .rst(rst), .accept(accept), .fin_ok(fin_ok),
    .fin_err(fin_err), .fin_kind(fin_kind), .fin_ea(fin_ea),
    .fin_opnd(fin_opnd), .busy(busy), .done(done), .err(err),
    .opnd_vld(opnd_vld), .opnd(opnd), .ea_vld(ea_vld), .ea(ea)
  );
endmodule

// File: rtl/eag_chk.sv
module eag_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic rd_en,
  input logic busy,
  input logic done,
  input logic err,
  input logic opnd_vld,
  input logic ea_vld
);
  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  // R11
  vld_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (opnd_vld || ea_vld) |-> done);
  // R10
  rd_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);
  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || err));
  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind opnd_addr_unit eag_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .busy(busy),
  .done(done), .err(err), .opnd_vld(opnd_vld), .ea_vld(ea_vld)
);

// File: tb/sim_opnd_addr_unit.sv
`timescale 1ns/1ps
module sim_opnd_addr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  xreg = '0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        busy, done, err, opnd_vld, ea_vld;
  logic [7:0]  opnd;
  logic [15:0] ea;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  opnd_addr_unit u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .pc(pc), .xreg(xreg),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .done(done), .err(err), .opnd_vld(opnd_vld), .opnd(opnd),
    .ea_vld(ea_vld), .ea(ea)
  );

  // memory model: hashed contents with a few directed overrides
  logic [7:0]  salt = 8'h3C;
  logic [15:0] ov_addr [8];
  logic [7:0]  ov_data [8];
  logic        ov_use  [8];

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [31:0] t;
    for (int i = 0; i < 8; i++)
      if (ov_use[i] && ov_addr[i] == a) return ov_data[i];
    t = {16'h0, a} * 32'd40503;
    return t[12:5] ^ salt ^ a[15:8];
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mem_byte(rd_addr);

  logic [15:0] rd_log [16];
  int rd_cnt = 0;
  always @(posedge clk) if (!rst && rd_en) begin
    rd_log[rd_cnt % 16] <= rd_addr;
    rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic string req_of(input int md);
    case (md)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic clear_ov();
    for (int i = 0; i < 8; i++) ov_use[i] = 1'b0;
  endtask

  task automatic set_ov(input int i, input logic [15:0] a, input logic [7:0] d);
    ov_addr[i] = a; ov_data[i] = d; ov_use[i] = 1'b1;
  endtask

  task automatic run_case(input int md, input logic [15:0] p,
                          input logic [7:0] xv, input bit poke);
    string rq;
    int lat_exp, nrd, base, lat;
    logic [15:0] ra [3];
    logic [7:0]  b1, ptr;
    logic [15:0] ea_exp;
    bit exp_done, exp_opnd, exp_ea;
    rq = req_of(md);
    b1 = mem_byte(p + 16'd1);
    exp_done = (md <= 6);
    exp_opnd = 0; exp_ea = 0; ea_exp = '0; nrd = 0; lat_exp = 1;
    ra[0] = p + 16'd1; ra[1] = '0; ra[2] = '0;
    case (md)
      2: begin lat_exp = 2; nrd = 1; exp_opnd = 1; end
      3: begin lat_exp = 3; nrd = 2; exp_ea = 1; ra[1] = p + 16'd2;
               ea_exp = {mem_byte(p + 16'd2), b1}; end
      4: begin lat_exp = 2; nrd = 1; exp_ea = 1; ea_exp = {8'h00, b1}; end
      5: begin lat_exp = 5; nrd = 3; exp_ea = 1; ptr = b1 + xv;
               ra[1] = {8'h00, ptr}; ra[2] = {8'h00, 8'(ptr + 8'd1)};
               ea_exp = {mem_byte(ra[2]), mem_byte(ra[1])}; end
      6: begin lat_exp = 2; nrd = 1; exp_ea = 1;
               ea_exp = p + {{8{b1[7]}}, b1}; end
      default: ;
    endcase
    @(negedge clk);
    start = 1'b1; mode = 4'(md); pc = p; xreg = xv; base = rd_cnt;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!(done || err) && lat < 16) begin
      chk(busy, "R9", "busy during op", busy, 1);
      if (poke && lat == 2) begin start = 1'b1; mode = 4'd3; pc = ~p; end
      else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(lat == lat_exp + 1, rq, "latency", lat - 1, lat_exp);
    chk(done == exp_done, rq, "done", done, exp_done);
    chk(err == !exp_done, (md > 6) ? "R8" : rq, "err", err, !exp_done);
    chk(opnd_vld == exp_opnd, rq, "opnd_vld", opnd_vld, exp_opnd);
    chk(ea_vld == exp_ea, rq, "ea_vld", ea_vld, exp_ea);
    chk(!busy, "R9", "busy at finish", busy, 0);
    if (exp_opnd) chk(opnd == b1, rq, "opnd", opnd, b1);
    if (exp_ea)   chk(ea == ea_exp, rq, "ea", ea, ea_exp);
    chk(rd_cnt - base == nrd, "R10", "read count", rd_cnt - base, nrd);
    for (int i = 0; i < nrd && i < 3; i++)
      chk(rd_log[(base + i) % 16] == ra[i], rq, "read addr",
          rd_log[(base + i) % 16], ra[i]);
    @(negedge clk);
    chk(!done && !err && !busy, "R11", "pulse ends", {done, err, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_ov();
    repeat (3) @(negedge clk);
    chk({busy, done, err, rd_en, opnd_vld, ea_vld} == 6'b0, "R1",
        "reset outputs", {busy, done, err, rd_en, opnd_vld, ea_vld}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, err, rd_en, opnd_vld, ea_vld} == 6'b0, "R1",
        "after reset", {busy, done, err, rd_en, opnd_vld, ea_vld}, 0);

    run_case(0, 16'h1000, 8'h00, 0);           // R2 implied
    run_case(1, 16'h1100, 8'h00, 0);           // R2 accumulator
    run_case(2, 16'h2000, 8'h00, 0);           // R3
    run_case(3, 16'hFFFE, 8'h00, 0);           // R4 pc wraps
    run_case(4, 16'h3456, 8'h00, 0);           // R5
    set_ov(0, 16'h0301, 8'hF0);                // R6 index wraps to 0x10
    run_case(5, 16'h0300, 8'h20, 0);
    clear_ov();
    set_ov(0, 16'h0401, 8'hFE);                // R6 pointer 0xFF, hi at 0x00
    set_ov(1, 16'h00FF, 8'h34);
    set_ov(2, 16'h0000, 8'h12);
    run_case(5, 16'h0400, 8'h01, 0);
    chk(ea == 16'h1234, "R6", "zp wrap ea", ea, 16'h1234);
    clear_ov();
    set_ov(0, 16'h0006, 8'h80);                // R7 negative offset
    run_case(6, 16'h0005, 8'h00, 0);
    chk(ea == 16'hFF85, "R7", "neg rel", ea, 16'hFF85);
    clear_ov();
    set_ov(0, 16'hFFF1, 8'h7F);                // R7 positive past top
    run_case(6, 16'hFFF0, 8'h00, 0);
    chk(ea == 16'h006F, "R7", "pos rel wrap", ea, 16'h006F);
    clear_ov();
    run_case(7, 16'h5000, 8'h00, 0);           // R8
    run_case(15, 16'h5100, 8'h00, 0);          // R8
    run_case(5, 16'h6000, 8'h44, 1);           // R9 start while busy

    for (int t = 0; t < 80; t++) begin
      int md;
      logic [15:0] p;
      logic [7:0] xv;
      salt = 8'($urandom(32'h51 + t));
      md = int'($urandom % 9);
      if (md == 8) md = 7 + int'($urandom % 9);
      p  = 16'($urandom);
      xv = 8'($urandom);
      run_case(md, p, xv, (t % 10) == 3);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule